// File: doc/BRIEF.md
# Privileged Trap Dispatcher

The dispatcher decides, cycle by cycle, whether the core leaves normal execution for privileged handler code. It weighs a synchronous exception request from the pipeline against four asynchronous interrupt lines. The interrupt lines are filtered by the current 3-bit interrupt priority level and by whether the core is already in privileged mode. When it accepts an event, the block forms the handler entry address from the privileged base register and a per-event offset. It also captures the return address with the old mode bit packed into bit 0, and it raises a one-cycle pulse that tells the core to redirect and switch to privileged mode.

Fixed events use offsets that are multiples of 0x80. Privileged-call requests take their offset from an 8-bit call code. Codes in the lower half land in one 64-byte-slot table and codes in the upper half land in a second table. Every result is registered, so the core sees the new PC, the saved address, the error code and the event cause one cycle after the request.

Top module: `trap_dispatch`

## Requirements
- R1: After reset, takePulse is 0 and newPc, excAddr, errCode and takenCause are all zero.
- R2: Cause encoding on excCause and takenCause: 0 reset, 1 machine check, 2 inter-processor, 3 clock, 4 device, 5 memory fault, 6 unaligned, 7 illegal opcode, 8 arithmetic, 9 FP disabled, 10 privileged call. For causes 0 to 9 the offset is cause·0x80, and newPc = privBase + offset.
- R3: For cause 10 with excCode bit 7 set, the offset is 0x2000 + (excCode − 0x80)·64. With bit 7 clear, the offset is 0x1000 + excCode·64.
- R4: excAddr equals the PC ORed with privMode in bit 0. For cause 8 (arithmetic), it is PC + 4 ORed with privMode.
- R5: irqPending bits are 0 device, 1 clock, 2 inter-processor and 3 machine check. Each is eligible only when ipl is at most 3, 4, 5 and 6 respectively, so at ipl 7 no interrupt is eligible.
- R6: Among eligible interrupts, machine check wins over inter-processor, which wins over clock, which wins over device.
- R7: No interrupt is taken while privMode is 1. A synchronous request is still taken.
- R8: A synchronous request beats any pending interrupt in the same cycle.
- R9: An event taken from an interrupt reports errCode 0. A synchronous event reports excCode.
- R10: All outputs update one cycle after the request. takePulse is high for exactly one cycle, and any request in that cycle is not accepted.
- R11: A synchronous request with a cause above 10 is ignored: no pulse, and the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqPending | input | 4 | Pending interrupt lines |
| ipl | input | 3 | Current interrupt priority level |
| privMode | input | 1 | Core is in privileged mode |
| excReq | input | 1 | Synchronous exception request |
| excCause | input | 4 | Synchronous exception cause |
| excCode | input | 8 | Exception code / privileged-call number |
| pcIn | input | 64 | PC of the faulting or interrupted instruction |
| privBase | input | 64 | Privileged code base address |
| newPc | output | 64 | Handler entry address |
| excAddr | output | 64 | Saved return address, mode in bit 0 |
| errCode | output | 8 | Error code handed to the handler |
| takenCause | output | 4 | Cause of the accepted event |
| takePulse | output | 1 | One-cycle redirect and enter-privileged strobe |

## Verification
The bench tests each level boundary (3/4, 4/5, 5/6, 6/7). A design with an off-by-one compare would accept or drop a line one level early. It tests call codes 0x00, 0x7F, 0x80 and 0xFF, where a wrong split or a missing subtraction of 0x80 moves the entry into the wrong table. It also drives every interrupt at once, and an interrupt together with a synchronous request. A wrong priority chain or a wrong sync-over-interrupt rule would then report the wrong cause. It further covers the arithmetic PC + 4 case, the mode bit in the saved address, the blocked cycle after a pulse, and an out-of-range cause. A design that got these wrong would report a stale return address, pulse twice in a row, or redirect on garbage.

// File: rtl/trap_dispatch_pkg.sv
package trap_dispatch_pkg;

  typedef enum logic [3:0] {
    CAUSE_RESET    = 4'd0,
    CAUSE_MCHK     = 4'd1,
    CAUSE_IPI      = 4'd2,
    CAUSE_CLOCK    = 4'd3,
    CAUSE_DEVICE   = 4'd4,
    CAUSE_MEMFAULT = 4'd5,
    CAUSE_UNALIGN  = 4'd6,
    CAUSE_OPCODE   = 4'd7,
    CAUSE_ARITH    = 4'd8,
    CAUSE_FPOFF    = 4'd9,
    CAUSE_PRIVCALL = 4'd10
  } cause_e;

  localparam int IRQ_LINES = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic   take;
    logic   fromIrq;
    logic   skipInsn;
    cause_e cause;
  } strobe_t;

endpackage

// File: rtl/trap_dispatch_ctrl.sv
module trap_dispatch_ctrl
  import trap_dispatch_pkg::*;
#(
  parameter int IPL_W    = 3,
  parameter int DEV_MAX  = 3,
  parameter int CLK_MAX  = 4,
  parameter int IPI_MAX  = 5,
  parameter int MCHK_MAX = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IRQ_LINES-1:0] irqPending,
  input  logic [IPL_W-1:0]     ipl,
  input  logic                 privMode,
  input  logic                 excReq,
  input  logic [3:0]           excCause,
  input  logic                 justTook,
  output strobe_t              strobe
);

  localparam int LEVEL_W = IPL_W + 1;

  function automatic int maxLevel(input int line);
    case (line)
      0:       return DEV_MAX;
      1:       return CLK_MAX;
      2:       return IPI_MAX;
      default: return MCHK_MAX;
    endcase
  endfunction

  function automatic cause_e lineCause(input int line);
    case (line)
      0:       return CAUSE_DEVICE;
      1:       return CAUSE_CLOCK;
      2:       return CAUSE_IPI;
      default: return CAUSE_MCHK;
    endcase
  endfunction

  logic [IRQ_LINES-1:0] eligible;
  logic [IRQ_LINES-1:0] grant;
  cause_e               irqCause;
  logic                 syncValid;
  logic                 irqValid;

  for (genvar g = 0; g < IRQ_LINES; g++) begin : g_elig
    localparam logic [LEVEL_W-1:0] LIMIT = LEVEL_W'(maxLevel(g));
    assign eligible[g] = irqPending[g] && ({1'b0, ipl} <= LIMIT);
  end

  // Highest line index wins
  always_comb begin
    grant    = '0;
    irqCause = CAUSE_DEVICE;
    for (int i = 0; i < IRQ_LINES; i++) begin
      if (eligible[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        irqCause = lineCause(i);
      end
    end
  end

  assign syncValid = excReq && (excCause <= 4'(CAUSE_PRIVCALL));
  assign irqValid  = !privMode && (|eligible);

  always_comb begin
    strobe          = '0;
    strobe.take     = !justTook && (syncValid || irqValid);
    strobe.fromIrq  = !syncValid;
    strobe.cause    = syncValid ? cause_e'(excCause) : irqCause;
    strobe.skipInsn = syncValid && (cause_e'(excCause) == CAUSE_ARITH);
  end

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R7
  priv_blocks_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (privMode && !excReq) |-> !strobe.take);

  // R5
  top_level_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&ipl) && !excReq) |-> !strobe.take);

endmodule

// File: rtl/trap_dispatch_dp.sv
module trap_dispatch_dp
  import trap_dispatch_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int CODE_W  = 8,
  parameter int INSN_B  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobe,
  input  logic [CODE_W-1:0] excCode,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic              privMode,
  input  logic [ADDR_W-1:0] privBase,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] excAddr,
  output logic [CODE_W-1:0] errCode,
  output logic [3:0]        takenCause,
  output logic              takePulse
);

  localparam int OFF_W      = 14;
  localparam int SLOT_SHIFT = 6;
  localparam int FIX_SHIFT  = 7;
  localparam logic [OFF_W-1:0] PRIV_TBL   = OFF_W'(14'h1000);
  localparam logic [OFF_W-1:0] UNPRIV_TBL = OFF_W'(14'h2000);

  logic [OFF_W-1:0]  offset;
  logic [CODE_W-2:0] slot;
  logic [ADDR_W-1:0] retPc;

  assign slot = excCode[CODE_W-2:0];

  always_comb begin
    if (strobe.cause == CAUSE_PRIVCALL) begin
      if (excCode[CODE_W-1])
        offset = UNPRIV_TBL + (OFF_W'(slot) << SLOT_SHIFT);
      else
        offset = PRIV_TBL + (OFF_W'(slot) << SLOT_SHIFT);
    end else begin
      offset = OFF_W'(strobe.cause) << FIX_SHIFT;
    end
  end

  assign retPc = strobe.skipInsn ? pcIn + ADDR_W'(INSN_B) : pcIn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      newPc      <= '0;
      excAddr    <= '0;
      errCode    <= '0;
      takenCause <= '0;
      takePulse  <= 1'b0;
    end else begin
      takePulse <= strobe.take;
      if (strobe.take) begin
        newPc      <= privBase + ADDR_W'(offset);
        excAddr    <= retPc | ADDR_W'(privMode);
        errCode    <= strobe.fromIrq ? '0 : excCode;
        takenCause <= strobe.cause;
      end
    end
  end

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    takePulse |=> !takePulse);

  // R2
  entry_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(takePulse) |-> (newPc[SLOT_SHIFT-1:0] == $past(privBase[SLOT_SHIFT-1:0])));

  // R4
  mode_bit_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(takePulse) |-> (excAddr[0] == ($past(privMode) | $past(pcIn[0]))));

endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
  import trap_dispatch_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CODE_W = 8,
  parameter int IPL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        irqPending,
  input  logic [IPL_W-1:0]  ipl,
  input  logic              privMode,
  input  logic              excReq,
  input  logic [3:0]        excCause,
  input  logic [CODE_W-1:0] excCode,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] privBase,
  output logic [ADDR_W-1:0] newPc,
  output logic [ADDR_W-1:0] excAddr,
  output logic [CODE_W-1:0] errCode,
  output logic [3:0]        takenCause,
  output logic              takePulse
);

  strobe_t strobe;

  trap_dispatch_ctrl #(.IPL_W(IPL_W)) ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .irqPending (irqPending),
    .ipl        (ipl),
    .privMode   (privMode),
    .excReq     (excReq),
    .excCause   (excCause),
    .justTook   (takePulse),
    .strobe     (strobe)
  );

  trap_dispatch_dp #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .excCode    (excCode),
    .pcIn       (pcIn),
    .privMode   (privMode),
    .privBase   (privBase),
    .newPc      (newPc),
    .excAddr    (excAddr),
    .errCode    (errCode),
    .takenCause (takenCause),
    .takePulse  (takePulse)
  );

endmodule

// File: tb/trap_dispatch_test.sv
module trap_dispatch_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  irqPending;
  logic [2:0]  ipl;
  logic        privMode;
  logic        excReq;
  logic [3:0]  excCause;
  logic [7:0]  excCode;
  logic [63:0] pcIn;
  logic [63:0] privBase;
  logic [63:0] newPc;
  logic [63:0] excAddr;
  logic [7:0]  errCode;
  logic [3:0]  takenCause;
  logic        takePulse;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  localparam logic [63:0] BASE = 64'h0000_0000_0010_0000;
  localparam logic [63:0] PC   = 64'h0000_0000_1234_5670;

  always #10 clk = ~clk;

  trap_dispatch uut (
    .clk(clk), .rst_n(rst_n), .irqPending(irqPending), .ipl(ipl),
    .privMode(privMode), .excReq(excReq), .excCause(excCause),
    .excCode(excCode), .pcIn(pcIn), .privBase(privBase), .newPc(newPc),
    .excAddr(excAddr), .errCode(errCode), .takenCause(takenCause),
    .takePulse(takePulse)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expOffset(input int cause, input int code);
    if (cause == 10)
      return (code >= 128) ? 64'(8192 + (code - 128) * 64) : 64'(4096 + code * 64);
    return 64'(cause * 128);
  endfunction

  task automatic idle();
    irqPending = '0; excReq = 0; excCause = '0; excCode = '0;
  endtask

  // Apply for one cycle, sample at the next falling edge
  task automatic fire(input logic [3:0] irq, input logic [2:0] lvl,
                      input logic pm, input logic req, input logic [3:0] cs,
                      input logic [7:0] code);
    irqPending = irq; ipl = lvl; privMode = pm; excReq = req;
    excCause = cs; excCode = code; pcIn = PC; privBase = BASE;
    @(negedge clk);
    idle();
  endtask

  task automatic expectTake(input string tag, input int cause, input int code,
                            input logic [63:0] addr, input logic [7:0] err);
    check(takePulse === 1'b1, tag, 64'(takePulse), 64'd1);
    check(takenCause === 4'(cause), tag, 64'(takenCause), 64'(cause));
    check(newPc === BASE + expOffset(cause, code), tag, newPc, BASE + expOffset(cause, code));
    check(excAddr === addr, tag, excAddr, addr);
    check(errCode === err, tag, 64'(errCode), 64'(err));
    @(negedge clk);
  endtask

  task automatic expectNone(input string tag);
    check(takePulse === 1'b0, tag, 64'(takePulse), 64'd0);
    @(negedge clk);
  endtask

  task automatic testReset();
    check(takePulse === 1'b0 && newPc === '0 && excAddr === '0 &&
          errCode === '0 && takenCause === '0, "R1 reset", newPc, 64'd0);
  endtask

  task automatic testFixedVectors();
    for (int c = 0; c < 10; c++) begin
      if (c == 8) continue;
      fire(4'h0, 3'd7, 1'b0, 1'b1, 4'(c), 8'h5A);
      expectTake("R2 fixed vector", c, 0, PC, 8'h5A);
    end
  endtask

  task automatic testPrivCall();
    int codes [4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    foreach (codes[i]) begin
      fire(4'h0, 3'd0, 1'b0, 1'b1, 4'd10, 8'(codes[i]));
      expectTake("R3 privileged call", 10, codes[i], PC, 8'(codes[i]));
    end
  endtask

  task automatic testSavedAddr();
    fire(4'h0, 3'd0, 1'b1, 1'b1, 4'd5, 8'h01);
    expectTake("R4 mode bit in saved address", 5, 0, PC | 64'd1, 8'h01);
    fire(4'h0, 3'd0, 1'b0, 1'b1, 4'd8, 8'h02);
    expectTake("R4 arithmetic next insn", 8, 0, PC + 64'd4, 8'h02);
    fire(4'h0, 3'd0, 1'b1, 1'b1, 4'd8, 8'h03);
    expectTake("R4 arithmetic next insn priv", 8, 0, (PC + 64'd4) | 64'd1, 8'h03);
  endtask

  task automatic testLevels();
    fire(4'b0001, 3'd3, 1'b0, 1'b0, 4'd0, 8'h77);
    expectTake("R5 device at 3", 4, 0, PC, 8'h00);
    fire(4'b0001, 3'd4, 1'b0, 1'b0, 4'd0, 8'h00);
    expectNone("R5 device masked at 4");
    fire(4'b0010, 3'd4, 1'b0, 1'b0, 4'd0, 8'h00);
    expectTake("R5 clock at 4", 3, 0, PC, 8'h00);
    fire(4'b0010, 3'd5, 1'b0, 1'b0, 4'd0, 8'h00);
    expectNone("R5 clock masked at 5");
    fire(4'b0100, 3'd5, 1'b0, 1'b0, 4'd0, 8'h00);
    expectTake("R5 ipi at 5", 2, 0, PC, 8'h00);
    fire(4'b0100, 3'd6, 1'b0, 1'b0, 4'd0, 8'h00);
    expectNone("R5 ipi masked at 6");
    fire(4'b1000, 3'd6, 1'b0, 1'b0, 4'd0, 8'h00);
    expectTake("R5 mchk at 6", 1, 0, PC, 8'h00);
    fire(4'b1111, 3'd7, 1'b0, 1'b0, 4'd0, 8'h00);
    expectNone("R5 all masked at 7");
  endtask

  task automatic testPriority();
    fire(4'b1111, 3'd0, 1'b0, 1'b0, 4'd0, 8'h00);
    expectTake("R6 mchk wins", 1, 0, PC, 8'h00);
    fire(4'b0111, 3'd0, 1'b0, 1'b0, 4'd0, 8'h00);
    expectTake("R6 ipi wins", 2, 0, PC, 8'h00);
    fire(4'b0011, 3'd0, 1'b0, 1'b0, 4'd0, 8'h00);
    expectTake("R6 clock wins", 3, 0, PC, 8'h00);
  endtask

  task automatic testPrivBlocks();
    fire(4'b1111, 3'd0, 1'b1, 1'b0, 4'd0, 8'h00);
    expectNone("R7 irq blocked in priv mode");
    fire(4'b1111, 3'd0, 1'b1, 1'b1, 4'd7, 8'h11);
    expectTake("R7 sync taken in priv mode", 7, 0, PC | 64'd1, 8'h11);
  endtask

  task automatic testSyncWins();
    fire(4'b1111, 3'd0, 1'b0, 1'b1, 4'd6, 8'h22);
    expectTake("R8 R9 sync beats irq", 6, 0, PC, 8'h22);
  endtask

  task automatic testPulse();
    irqPending = '0; ipl = 3'd7; privMode = 0; excReq = 1;
    excCause = 4'd9; excCode = 8'h33; pcIn = PC; privBase = BASE;
    @(negedge clk);
    check(takePulse === 1'b1, "R10 first take", 64'(takePulse), 64'd1);
    @(negedge clk);
    check(takePulse === 1'b0, "R10 blocked cycle", 64'(takePulse), 64'd0);
    @(negedge clk);
    check(takePulse === 1'b1, "R10 taken again", 64'(takePulse), 64'd1);
    idle();
    @(negedge clk);
    check(takePulse === 1'b0, "R10 pulse ends", 64'(takePulse), 64'd0);
  endtask

  task automatic testBadCause();
    logic [63:0] prevPc;
    prevPc = newPc;
    fire(4'h0, 3'd7, 1'b0, 1'b1, 4'd12, 8'h44);
    check(takePulse === 1'b0, "R11 bad cause no pulse", 64'(takePulse), 64'd0);
    check(newPc === prevPc, "R11 bad cause holds newPc", newPc, prevPc);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; ipl = '0; privMode = 0; pcIn = '0; privBase = '0;
    idle();
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1;
    @(negedge clk);
    testFixedVectors();
    testPrivCall();
    testSavedAddr();
    testLevels();
    testPriority();
    testPrivBlocks();
    testSyncWins();
    testPulse();
    testBadCause();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule